// File: doc/BRIEF.md
# Scaling-free CORDIC vector rotator

This block turns a 16-bit two's-complement vector (x, y) clockwise through a signed angle, using only arithmetic shifts and additions. Each fine step replaces the sine of a small angle by 2^-i and the cosine by 1 − 2^-(2i+1). The gain of each step is therefore within about 2^-(4i+2) of one, and the result leaves the block with no scaling multiply and no correction passes.

A caller presents x, y and an angle with a one-cycle start pulse while the block is idle. The block first removes whole quarter turns by exact swap-and-negate moves. It then applies one fine step per clock, chosen greedily from the remaining angle. When nothing admissible is left, it raises done for a single cycle and holds the rotated vector on its outputs until the next start is accepted.

Top module: `cordic_vec_rotator`

## Requirements
- R1: After reset, busy and done are 0 and both x_out and y_out are 0.
- R2: A start pulse is accepted when busy is 0, including the cycle in which done is high. busy is 1 in the cycle after an acceptance. A start pulse while busy is 1 has no effect on the operation in flight or on its result.
- R3: angle_in is a signed 18-bit value in radians with 15 fraction bits, and a positive value means clockwise. The result approximates x·cosθ + y·sinθ for x_out and −x·sinθ + y·cosθ for y_out, within 0.3 % of the input magnitude plus 96 LSB, for inputs whose components lie within ±20000.
- R4: While the remaining angle is above 25736 (π/4), one cycle maps (x, y) to (y, −x) and subtracts 51472 (π/2). While it is below −25736, one cycle maps (x, y) to (−y, x) and adds 51472. A negation of −32768 gives 32767.
- R5: Once the remaining angle r is within ±25736 and not finished, one cycle applies a fine step with the smallest i in 4..15 for which 2^(15−i) ≤ |r|. The step is clockwise if r > 0, and 2^(15−i) is then subtracted from r. Otherwise the step is counter-clockwise and 2^(15−i) is added to r. The same i may be chosen again.
- R6: A clockwise fine step computes x' = x − (x>>>(2i+1)) + (y>>>i) and y' = y − (y>>>(2i+1)) − (x>>>i). A counter-clockwise step flips the sign of the last term in each. Both use the x and y from before the step, use arithmetic shifts that truncate toward minus infinity, and saturate each result to [−32768, 32767].
- R7: When |r| is below 2^(15−15), so that no index is admissible, done is 1 for exactly one cycle and busy falls in that same cycle.
- R8: If an operation needs n quarter turns and fine steps, done is high in the cycle that follows the (n+1)-th rising clock edge after the accepting edge.
- R9: While the block is idle and start stays low, x_out and y_out do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a rotation with the present operands |
| x_in | input | 16 | Signed x component of the input vector |
| y_in | input | 16 | Signed y component of the input vector |
| angle_in | input | 18 | Signed clockwise angle, radians, 15 fraction bits |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| x_out | output | 16 | Signed x component of the rotated vector |
| y_out | output | 16 | Signed y component of the rotated vector |

## Verification
Two functions can fall in the same cycle: completion of one rotation, shown by the done pulse, and acceptance of the next start. The bench drives a new start with fresh operands in the very cycle that done is high. It first reads the finished result in that cycle. It then checks that busy rises on the next cycle and that the second result and latency match the bench model. A start pulsed in the middle of a busy period is judged by comparing the final result and latency with those of the undisturbed operation.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rot_state_e;

  // decision for the current cycle of an operation
  typedef struct packed {
    logic quarter;   // take a quarter-turn this cycle
    logic q_cw;      // quarter-turn direction is clockwise
    logic fine_cw;   // fine step direction is clockwise
    logic finished;  // no admissible index remains
  } step_ctl_t;

endpackage

// File: rtl/cordic_ashift.sv
module cordic_ashift #(
  parameter int W  = 16,
  parameter int SW = 5
) (
  input  logic signed [W-1:0] din,
  input  logic        [SW-1:0] amt,
  output logic signed [W-1:0] dout
);

  logic signed [W-1:0] stg [0:SW];

  assign stg[0] = din;

  // logarithmic barrel: stage k shifts by 2**k when amt[k] is set
  for (genvar k = 0; k < SW; k++) begin : g_stage
    assign stg[k+1] = amt[k] ? (stg[k] >>> (2 ** k)) : stg[k];
  end

  assign dout = stg[SW];

endmodule

// File: rtl/cordic_sat_acc.sv
module cordic_sat_acc #(
  parameter int W = 16,
  parameter int G = 2
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  input  logic signed [W-1:0] c,
  input  logic                sub_c,
  output logic signed [W-1:0] y
);

  localparam int WW = W + G;
  localparam logic signed [WW-1:0] MAXV = {{(G+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [WW-1:0] MINV = {{(G+1){1'b1}}, {(W-1){1'b0}}};

  logic signed [WW-1:0] aw, bw, cw, sum;

  always_comb begin
    aw  = {{G{a[W-1]}}, a};
    bw  = {{G{b[W-1]}}, b};
    cw  = {{G{c[W-1]}}, c};
    sum = sub_c ? (aw - bw - cw) : (aw - bw + cw);
    if (sum > MAXV) begin
      y = MAXV[W-1:0];
    end else if (sum < MINV) begin
      y = MINV[W-1:0];
    end else begin
      y = sum[W-1:0];
    end
  end

endmodule

// File: rtl/cordic_micro_rot.sv
module cordic_micro_rot #(
  parameter int DW   = 16,
  parameter int IDXW = 4,
  parameter int SHW  = 5,
  parameter int G    = 2
) (
  input  logic signed [DW-1:0]   x,
  input  logic signed [DW-1:0]   y,
  input  logic        [IDXW-1:0] idx,
  input  logic                   cw,
  output logic signed [DW-1:0]   xn,
  output logic signed [DW-1:0]   yn
);

  logic signed [DW-1:0] cur [0:1];
  logic signed [DW-1:0] res [0:1];
  logic        [SHW-1:0] amt_cos, amt_sin;

  assign cur[0]  = x;
  assign cur[1]  = y;
  assign amt_cos = SHW'({idx, 1'b1});   // 2i+1
  assign amt_sin = SHW'(idx);           // i

  // one lane per axis; each reads only the pre-step values
  for (genvar c = 0; c < 2; c++) begin : g_axis
    localparam int OTH = 1 - c;
    logic signed [DW-1:0] cos_t, sin_t;

    cordic_ashift #(.W(DW), .SW(SHW)) u_cos_sh (
      .din (cur[c]),
      .amt (amt_cos),
      .dout(cos_t)
    );

    cordic_ashift #(.W(DW), .SW(SHW)) u_sin_sh (
      .din (cur[OTH]),
      .amt (amt_sin),
      .dout(sin_t)
    );

    cordic_sat_acc #(.W(DW), .G(G)) u_acc (
      .a    (cur[c]),
      .b    (cos_t),
      .c    (sin_t),
      .sub_c((c == 0) ? ~cw : cw),
      .y    (res[c])
    );
  end

  assign xn = res[0];
  assign yn = res[1];

endmodule

// File: rtl/cordic_step_sel.sv
module cordic_step_sel
  import cordic_rot_pkg::*;
#(
  parameter int AW    = 18,
  parameter int AFRAC = 15,
  parameter int IMIN  = 4,
  parameter int IMAX  = 15,
  parameter int IDXW  = 4,
  parameter int QTR   = 25736,
  parameter int HALF  = 51472
) (
  input  logic signed [AW-1:0]   rem,
  output step_ctl_t              ctl,
  output logic        [IDXW-1:0] idx,
  output logic signed [AW-1:0]   rem_next
);

  localparam logic signed [AW-1:0] HALF_C = AW'(HALF);

  logic signed [AW:0] rem_w;
  logic        [AW:0] mag;
  logic               q_pos, q_neg, hit;
  logic signed [AW-1:0] fine_amt;

  always_comb begin
    rem_w = {rem[AW-1], rem};
    mag   = (rem_w < 0) ? unsigned'(-rem_w) : unsigned'(rem_w);
    q_pos = (int'(rem) > QTR);
    q_neg = (int'(rem) < -QTR);
  end

  // greedy: smallest index whose elementary angle fits in |rem|
  always_comb begin
    idx = IDXW'(IMAX);
    hit = 1'b0;
    for (int i = IMAX; i >= IMIN; i--) begin
      if (int'(mag) >= (1 << (AFRAC - i))) begin
        idx = IDXW'(i);
        hit = 1'b1;
      end
    end
    fine_amt = {{(AW-1){1'b0}}, 1'b1} << (AFRAC - int'(idx));
  end

  always_comb begin
    ctl.quarter  = q_pos | q_neg;
    ctl.q_cw     = q_pos;
    ctl.fine_cw  = ~rem[AW-1];
    ctl.finished = ~(q_pos | q_neg) & ~hit;
    if (q_pos) begin
      rem_next = rem - HALF_C;
    end else if (q_neg) begin
      rem_next = rem + HALF_C;
    end else if (!rem[AW-1]) begin
      rem_next = rem - fine_amt;
    end else begin
      rem_next = rem + fine_amt;
    end
  end

endmodule

// File: rtl/cordic_vec_rotator.sv
module cordic_vec_rotator
  import cordic_rot_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 18,
  parameter int AFRAC = 15,
  parameter int IMIN  = 4,
  parameter int IMAX  = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [DW-1:0] x_in,
  input  logic signed [DW-1:0] y_in,
  input  logic signed [AW-1:0] angle_in,
  output logic                 busy,
  output logic                 done,
  output logic signed [DW-1:0] x_out,
  output logic signed [DW-1:0] y_out
);

  localparam int IDXW  = $clog2(IMAX + 1);
  localparam int SHW   = IDXW + 1;
  localparam int GUARD = 2;
  localparam int HALF  = int'(1.5707963267948966 * (2.0 ** AFRAC));
  localparam int QTR   = int'(0.7853981633974483 * (2.0 ** AFRAC));
  localparam logic signed [DW-1:0] MAX_S = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MIN_S = {1'b1, {(DW-1){1'b0}}};

  // ---------------- reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_sn = rst_pipe[1];

  // ---------------- state
  rot_state_e           st_q, st_d;
  logic signed [DW-1:0] x_q, x_d, y_q, y_d;
  logic signed [AW-1:0] r_q, r_d;
  logic                 done_q, done_d;
  logic                 en;

  step_ctl_t            ctl;
  logic [IDXW-1:0]      idx;
  logic signed [AW-1:0] r_step;
  logic signed [DW-1:0] x_fine, y_fine;

  cordic_step_sel #(
    .AW(AW), .AFRAC(AFRAC), .IMIN(IMIN), .IMAX(IMAX),
    .IDXW(IDXW), .QTR(QTR), .HALF(HALF)
  ) u_sel (
    .rem     (r_q),
    .ctl     (ctl),
    .idx     (idx),
    .rem_next(r_step)
  );

  cordic_micro_rot #(
    .DW(DW), .IDXW(IDXW), .SHW(SHW), .G(GUARD)
  ) u_rot (
    .x  (x_q),
    .y  (y_q),
    .idx(idx),
    .cw (ctl.fine_cw),
    .xn (x_fine),
    .yn (y_fine)
  );

  function automatic logic signed [DW-1:0] neg_sat(input logic signed [DW-1:0] v);
    return (v == MIN_S) ? MAX_S : -v;
  endfunction

  // ---------------- next state
  always_comb begin
    st_d   = st_q;
    x_d    = x_q;
    y_d    = y_q;
    r_d    = r_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          x_d  = x_in;
          y_d  = y_in;
          r_d  = angle_in;
          st_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (ctl.quarter) begin
          if (ctl.q_cw) begin
            x_d = y_q;
            y_d = neg_sat(x_q);
          end else begin
            x_d = neg_sat(y_q);
            y_d = x_q;
          end
          r_d = r_step;
        end else if (ctl.finished) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          x_d = x_fine;
          y_d = y_fine;
          r_d = r_step;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign en = (st_q == ST_RUN) | start;

  // ---------------- registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      x_q <= '0;
      y_q <= '0;
      r_q <= '0;
    end else if (en) begin
      x_q <= x_d;
      y_q <= y_d;
      r_q <= r_d;
    end
  end

  assign busy  = (st_q == ST_RUN);
  assign done  = done_q;
  assign x_out = x_q;
  assign y_out = y_q;

  // ---------------- checks
  logic signed [AW:0] r_w;
  logic        [AW:0] r_mag;
  logic               fine_step;

  assign r_w       = {r_q[AW-1], r_q};
  assign r_mag     = (r_w < 0) ? unsigned'(-r_w) : unsigned'(r_w);
  assign fine_step = busy & ~ctl.quarter & ~ctl.finished;

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_sn)
    (start && !busy) |=> busy);  // R2

  AST_QUARTER_BOUND: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && !ctl.quarter) |-> (int'(r_mag) <= QTR));  // R4

  AST_REM_SHRINKS: assert property (@(posedge clk) disable iff (!rst_sn)
    fine_step |=> (r_mag < $past(r_mag)));  // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done);  // R7

  AST_FINISH_DONE: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && ctl.finished) |=> (done && !busy));  // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (!busy && !start) |=> ($stable(x_out) && $stable(y_out)));  // R9

endmodule

// File: tb/tb_cordic_vec_rotator.sv
module tb_cordic_vec_rotator;

  localparam int DW = 16, AW = 18, AFRAC = 15, IMIN = 4, IMAX = 15;
  localparam int QTR = 25736, HALF = 51472;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 start = 1'b0;
  logic signed [DW-1:0] x_in = '0;
  logic signed [DW-1:0] y_in = '0;
  logic signed [AW-1:0] angle_in = '0;
  logic                 busy, done;
  logic signed [DW-1:0] x_out, y_out;

  int  checks = 0;
  int  fails  = 0;
  int  cyc    = 0;
  bit  ended  = 1'b0;

  always #4 clk = ~clk;

  cordic_vec_rotator dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_in(x_in), .y_in(y_in), .angle_in(angle_in),
    .busy(busy), .done(done), .x_out(x_out), .y_out(y_out)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !ended) begin
      ended = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // bit-exact behaviour from R4, R5, R6, R7
  function automatic void model(input int xi, input int yi, input int ai,
                                output int xo, output int yo, output int n);
    int x, y, r, t, a, i, cx, sx, cy, sy;
    x = xi; y = yi; r = ai; n = 0;
    for (int g = 0; g < 1000; g++) begin
      if (r > QTR) begin
        t = x; x = y; y = sat(-t); r -= HALF; n++;
      end else if (r < -QTR) begin
        t = x; x = sat(-y); y = t; r += HALF; n++;
      end else begin
        a = (r < 0) ? -r : r;
        if (a < (1 << (AFRAC - IMAX))) break;
        i = IMIN;
        while ((1 << (AFRAC - i)) > a) i++;
        cx = x >>> (2*i+1); sx = x >>> i;
        cy = y >>> (2*i+1); sy = y >>> i;
        if (r > 0) begin
          t = sat(x - cx + sy); y = sat(y - cy - sx); x = t; r -= (1 << (AFRAC - i));
        end else begin
          t = sat(x - cx - sy); y = sat(y - cy + sx); x = t; r += (1 << (AFRAC - i));
        end
        n++;
      end
    end
    xo = x; yo = y;
  endfunction

  // called at a negedge; start is taken at the following posedge
  task automatic launch(int xi, int yi, int ai);
    x_in = DW'(xi); y_in = DW'(yi); angle_in = AW'(ai);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int c0, output int cnt, output bit ok);
    cnt = c0;
    while (!done && cnt < 400) begin
      @(negedge clk);
      cnt++;
    end
    ok = done;
  endtask

  task automatic judge(string tag, int xi, int yi, int ai, int cnt, bit ok);
    int ex, ey, n;
    model(xi, yi, ai, ex, ey, n);
    if (!ok) begin
      checks++; fails++;
      $display("FAIL R7 %s timeout: actual no done expected done", tag);
    end
    check("R6", {tag, " x"}, int'(x_out), ex);
    check("R6", {tag, " y"}, int'(y_out), ey);
    check("R8", {tag, " latency"}, cnt, n + 1);
  endtask

  task automatic one_op(string tag, int xi, int yi, int ai);
    int cnt; bit ok;
    launch(xi, yi, ai);
    wait_done(0, cnt, ok);
    judge(tag, xi, yi, ai, cnt, ok);
  endtask

  task automatic ideal(int xi, int yi, int ai);
    real th, ex, ey, tol, dx, dy;
    th  = real'(ai) / 32768.0;
    ex  = xi * $cos(th) + yi * $sin(th);
    ey  = -xi * $sin(th) + yi * $cos(th);
    tol = 0.003 * $sqrt(real'(xi) * xi + real'(yi) * yi) + 96.0;
    dx  = real'(x_out) - ex;
    dy  = real'(y_out) - ey;
    checks++;
    if (dx > tol || -dx > tol || dy > tol || -dy > tol) begin
      fails++;
      $display("FAIL R3 rotation: actual (%0d,%0d) expected (%0.1f,%0.1f)",
               x_out, y_out, ex, ey);
    end
  endtask

  initial begin
    int cnt, xa, ya, aa, xb, yb, ab, hx, hy;
    bit ok;
    void'($urandom(20240611));

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "x_out", int'(x_out), 0);
    check("R1", "y_out", int'(y_out), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // directed corners
    one_op("zero angle", 1234, -567, 0);                       // R7 R8
    check("R8", "zero angle x kept", int'(x_out), 1234);
    one_op("quarter cw", 1000, -2000, HALF);                   // R4
    check("R4", "quarter cw x", int'(x_out), -2000);
    check("R4", "quarter cw y", int'(y_out), -1000);
    one_op("quarter ccw", 1000, -2000, -HALF);                 // R4
    check("R4", "quarter ccw x", int'(x_out), 2000);
    check("R4", "quarter ccw y", int'(y_out), 1000);
    one_op("negate min", -32768, 5, HALF);                     // R4 saturating negate
    check("R4", "negate min y", int'(y_out), 32767);
    one_op("single lsb", 20000, -20000, 1);                    // R5 i=15
    one_op("index 4 exact", 8000, 3000, 2048);                 // R5 i=4
    one_op("index reuse", -8000, 3000, -6145);                 // R5 reuse of i
    one_op("saturate", 32767, 32767, 25000);                   // R6
    one_op("max angle", 15000, 9000, 131071);
    one_op("min angle", -15000, 9000, -131072);

    // R7 single cycle pulse and R9 hold while idle
    launch(3000, 4000, 12345);
    wait_done(0, cnt, ok);
    hx = int'(x_out); hy = int'(y_out);
    @(negedge clk);
    check("R7", "done width", int'(done), 0);
    check("R7", "busy after done", int'(busy), 0);
    x_in = 16'sd77; y_in = -16'sd77; angle_in = 18'sd999;
    repeat (4) @(negedge clk);
    check("R9", "hold x", int'(x_out), hx);
    check("R9", "hold y", int'(y_out), hy);

    // R2: start during busy is ignored
    xa = 7000; ya = -3000; aa = 70000;
    launch(xa, ya, aa);
    x_in = 16'sd111; y_in = 16'sd222; angle_in = 18'sd333; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(1, cnt, ok);
    judge("R2 start while busy", xa, ya, aa, cnt, ok);

    // R2: new start in the done cycle
    xb = -12000; yb = 500; ab = -40000;
    launch(xa, ya, aa);
    wait_done(0, cnt, ok);
    judge("R2 first of pair", xa, ya, aa, cnt, ok);
    launch(xb, yb, ab);
    check("R2", "busy after start in done cycle", int'(busy), 1);
    wait_done(0, cnt, ok);
    judge("R2 second of pair", xb, yb, ab, cnt, ok);

    // random, moderate magnitude: bit exact plus true rotation (R3)
    for (int k = 0; k < 60; k++) begin
      xa = int'($urandom_range(40000)) - 20000;
      ya = int'($urandom_range(40000)) - 20000;
      aa = int'($urandom_range(262143)) - 131072;
      one_op("random", xa, ya, aa);
      ideal(xa, ya, aa);
    end

    // random, full scale: saturation paths (R6)
    for (int k = 0; k < 40; k++) begin
      xa = int'($urandom_range(65535)) - 32768;
      ya = int'($urandom_range(65535)) - 32768;
      aa = int'($urandom_range(262143)) - 131072;
      one_op("full scale", xa, ya, aa);
    end

    ended = 1'b1;
    summary();
    $finish;
  end

endmodule